// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the master side of a two-wire station management link. It reads and writes 16-bit registers in attached PHY devices. A host raises a one-cycle start strobe together with a direction select, a PHY address, a register address and, for writes, a data word. The block then produces the whole serial frame on its own. It derives the management clock from the system clock, runs the all-ones preamble, the start and opcode pairs, both address fields and the turnaround, and shifts the data in or out. It ends every frame with one idle clock.

The master controls the output enable of an external tri-state pad and releases the line whenever the PHY is to drive it. When the PHY does not pull the read turnaround bit low, the master still clocks a flush of further cycles so that a confused PHY can empty its shift register. It then reports all-ones data and raises an error flag. The low and high times of the management clock are counts of system-clock cycles, set by parameters. Receive bits have a separate, longer high time so that the PHY has time to answer. Parameters below 1 are rejected at elaboration.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever no frame is in progress, `mdc_o` is 0, `mdio_oe_o` is 0 and `done_o` is 0. After reset, `rd_data_o` and `err_o` are 0.
- R2: A frame begins with PRE_BITS (32) MDC cycles. In each of them `mdio_oe_o` is 1 and `mdio_o` is 1 when MDC rises.
- R3: After the preamble come the bits 0 then 1. The opcode follows: 1,0 when `rd_nwr_i` is 1 (read) and 0,1 when it is 0 (write). All four are driven with `mdio_oe_o` = 1.
- R4: The 5-bit PHY address follows, then the 5-bit register address, each sent most-significant bit first.
- R5: A write then drives 1,0 and the 16 data bits MSB first. It then deasserts `mdio_oe_o` for one final MDC cycle, so a write has 65 MDC cycles in all.
- R6: A read deasserts `mdio_oe_o` right after the register address. If the sampled turnaround bit is 0, it samples 16 data bits MSB first into `rd_data_o` and adds one idle cycle, so the read has 64 MDC cycles. It then completes with `err_o` = 0.
- R7: If the sampled read turnaround bit is 1, the master clocks FLUSH_BITS (32) more MDC cycles and captures nothing. It then completes with `rd_data_o` = 16'hFFFF and `err_o` = 1, for 79 MDC cycles in all.
- R8: For a driven bit, `mdio_o` takes its new value when MDC goes low. MDC stays low for HALF_CYC clock cycles and then high for HALF_CYC cycles. `mdio_o` and `mdio_oe_o` never change while MDC is high.
- R9: For a received bit (turnaround, read data, flush and the trailing idle cycle), MDC stays low for HALF_CYC cycles and high for READ_HI_CYC cycles. `mdio_i` is sampled on the clock edge at which MDC falls.
- R10: A start strobe while a frame is in progress is ignored. The running frame is unchanged, and no second frame follows.
- R11: `done_o` is a one-cycle pulse at the end of each frame. `rd_data_o` and `err_o` change only in that cycle and hold until the next completion. A write completion clears `err_o` and leaves `rd_data_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle request to begin a frame |
| rd_nwr_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | ADDR_W | PHY address |
| reg_addr_i | input | ADDR_W | Register address |
| wr_data_i | input | DATA_W | Data for a write |
| rd_data_o | output | DATA_W | Data from the last read (all ones after a failed read) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last read saw no turnaround from the PHY |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data driven to the pad |
| mdio_oe_o | output | 1 | Pad output enable |
| mdio_i | input | 1 | Data read from the pad |

## Verification
The hardest case to reach from the ports is the failed-turnaround path. The bench reaches it with a PHY model that follows MDC rising edges and counts them. On the 47th edge it drives a chosen turnaround value, either 0 for a good read or 1 for a flush. On later edges it supplies a computed data word. Starts that arrive while a frame is running are also hard to hit. The bench injects them in the middle of the preamble and checks that the frame goes on unchanged, with a single completion pulse. A sweep over all 32 addresses with arithmetic data words runs writes, good reads and failed reads, and a write after a failed read shows that the error clears while the data holds.

// File: rtl/mdio_master_pkg.sv
package mdio_master_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_HDR,
      ST_WDAT,
      ST_TA,
      ST_RDAT,
      ST_FLUSH,
      ST_TAIL
   } mdio_seq_e;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mdc_phase_timer.sv
module mdc_phase_timer #(
   parameter int TW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/mdio_rx_shift.sv
module mdio_rx_shift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         shift_en,
   input  logic         bit_in,
   output logic [W-1:0] value
);

   logic [W-1:0] sh_q;

   generate
      if (W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q <= '0;
            else if (clr)     sh_q <= '0;
            else if (shift_en) sh_q <= bit_in;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       sh_q <= '0;
            else if (clr)     sh_q <= '0;
            else if (shift_en) sh_q <= {sh_q[W-2:0], bit_in};
         end
      end
   endgenerate

   assign value = sh_q;

endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_master_pkg::*;
#(
   parameter int HALF_CYC    = 25,
   parameter int READ_HI_CYC = 35,
   parameter int PRE_BITS    = 32,
   parameter int FLUSH_BITS  = 32,
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_nwr_i,
   input  logic [ADDR_W-1:0] phy_addr_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [DATA_W-1:0] rd_data_o,
   output logic              done_o,
   output logic              err_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);

   localparam int HDR_BITS = 4 + 2 * ADDR_W;
   localparam int SR_W     = HDR_BITS + 2 + DATA_W;
   localparam int TMAX     = max_u(HALF_CYC, READ_HI_CYC);
   localparam int TW       = $clog2(TMAX + 1);
   localparam int CMAX     = max_u(max_u(PRE_BITS, FLUSH_BITS), max_u(DATA_W + 2, HDR_BITS));
   localparam int CW       = $clog2(CMAX + 1);

   // elaboration-time parameter checks
   generate
      if (HALF_CYC < 1) begin : g_bad_half
         $error("HALF_CYC must be at least 1");
      end
      if (READ_HI_CYC < 1) begin : g_bad_rdhi
         $error("READ_HI_CYC must be at least 1");
      end
      if (PRE_BITS < 1 || FLUSH_BITS < 1) begin : g_bad_cnt
         $error("PRE_BITS and FLUSH_BITS must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_w
         $error("field widths too small");
      end
   endgenerate

   mdio_seq_e         state;
   logic              phase_hi;
   logic [CW-1:0]     bitcnt;
   logic [SR_W-1:0]   sr;
   logic              op_rd;
   logic              mdc_q, mdo_q, oe_q, done_q, err_q;
   logic [DATA_W-1:0] rd_q;
   logic              busy_w;

   logic              rx_bit;
   logic              tmr_load, tmr_exp;
   logic [TW-1:0]     tmr_val;
   logic              bit_end;
   logic              accept;
   logic [DATA_W-1:0] rx_val;
   logic              rx_shift;

   assign busy_w   = (state != ST_IDLE);
   assign accept   = (state == ST_IDLE) && start_i;
   assign rx_bit   = (state == ST_TA) || (state == ST_RDAT) ||
                     (state == ST_FLUSH) || (state == ST_TAIL);
   assign bit_end  = busy_w && tmr_exp && phase_hi;
   assign tmr_load = accept || (busy_w && tmr_exp);
   assign rx_shift = bit_end && (state == ST_RDAT);

   always_comb begin
      if (busy_w && !phase_hi && rx_bit)
         tmr_val = TW'(READ_HI_CYC - 1);
      else
         tmr_val = TW'(HALF_CYC - 1);
   end

   mdc_phase_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_exp)
   );

   mdio_rx_shift #(.W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (accept),
      .shift_en (rx_shift),
      .bit_in   (mdio_i),
      .value    (rx_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         phase_hi <= 1'b0;
         bitcnt   <= '0;
         sr       <= '0;
         op_rd    <= 1'b0;
         mdc_q    <= 1'b0;
         mdo_q    <= 1'b0;
         oe_q     <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         rd_q     <= '0;
      end else begin
         done_q <= 1'b0;
         if (accept) begin
            state    <= ST_PRE;
            bitcnt   <= CW'(PRE_BITS - 1);
            phase_hi <= 1'b0;
            mdc_q    <= 1'b0;
            oe_q     <= 1'b1;
            mdo_q    <= 1'b1;
            op_rd    <= rd_nwr_i;
            sr       <= {2'b01, (rd_nwr_i ? 2'b10 : 2'b01), phy_addr_i, reg_addr_i,
                         2'b10, wr_data_i};
         end else if (busy_w && tmr_exp && !phase_hi) begin
            mdc_q    <= 1'b1;
            phase_hi <= 1'b1;
         end else if (bit_end) begin
            mdc_q    <= 1'b0;
            phase_hi <= 1'b0;
            bitcnt   <= bitcnt - 1'b1;
            case (state)
               ST_PRE: begin
                  if (bitcnt == '0) begin
                     state  <= ST_HDR;
                     bitcnt <= CW'(HDR_BITS - 1);
                     mdo_q  <= sr[SR_W-1];
                  end
               end
               ST_HDR: begin
                  if (bitcnt == '0 && op_rd) begin
                     state <= ST_TA;
                     oe_q  <= 1'b0;
                     mdo_q <= 1'b0;
                  end else begin
                     sr    <= sr << 1;
                     mdo_q <= sr[SR_W-2];
                     if (bitcnt == '0) begin
                        state  <= ST_WDAT;
                        bitcnt <= CW'(DATA_W + 1);
                     end
                  end
               end
               ST_WDAT: begin
                  if (bitcnt == '0) begin
                     state <= ST_TAIL;
                     oe_q  <= 1'b0;
                     mdo_q <= 1'b0;
                  end else begin
                     sr    <= sr << 1;
                     mdo_q <= sr[SR_W-2];
                  end
               end
               ST_TA: begin
                  if (mdio_i) begin
                     state  <= ST_FLUSH;
                     bitcnt <= CW'(FLUSH_BITS - 1);
                  end else begin
                     state  <= ST_RDAT;
                     bitcnt <= CW'(DATA_W - 1);
                  end
               end
               ST_RDAT: begin
                  if (bitcnt == '0) state <= ST_TAIL;
               end
               ST_FLUSH: begin
                  if (bitcnt == '0) begin
                     state  <= ST_IDLE;
                     done_q <= 1'b1;
                     rd_q   <= '1;
                     err_q  <= 1'b1;
                  end
               end
               ST_TAIL: begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
                  err_q  <= 1'b0;
                  if (op_rd) rd_q <= rx_val;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   assign mdc_o     = mdc_q;
   assign mdio_o    = mdo_q;
   assign mdio_oe_o = oe_q;
   assign done_o    = done_q;
   assign err_o     = err_q;
   assign rd_data_o = rd_q;

endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int HALF_CYC    = 25,
   parameter int READ_HI_CYC = 35,
   parameter int DATA_W      = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mdc_o,
   input logic              mdio_o,
   input logic              mdio_oe_o,
   input logic              done_o,
   input logic              err_o,
   input logic [DATA_W-1:0] rd_data_o,
   input logic              busy
);

   logic [15:0] hi_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hi_len <= '0;
      else if (mdc_o) hi_len <= hi_len + 1'b1;
      else            hi_len <= '0;
   end

   // R1
   idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdc_o && !mdio_oe_o));

   // R11
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R11
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data_o != $past(rd_data_o)) || (err_o != $past(err_o))) |-> done_o);

   // R7
   err_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (rd_data_o == '1));

   // R8
   tx_stable_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc_o && $past(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

   // R8 R9
   hi_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc_o) |-> (hi_len == ($past(mdio_oe_o) ? 16'(HALF_CYC) : 16'(READ_HI_CYC))));

   // R6
   oe_drop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdio_oe_o) |-> !mdc_o);

endmodule

bind mdio_master mdio_master_chk #(
   .HALF_CYC    (HALF_CYC),
   .READ_HI_CYC (READ_HI_CYC),
   .DATA_W      (DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mdc_o     (mdc_o),
   .mdio_o    (mdio_o),
   .mdio_oe_o (mdio_oe_o),
   .done_o    (done_o),
   .err_o     (err_o),
   .rd_data_o (rd_data_o),
   .busy      (busy_w)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;

   localparam int CLK_PERIOD = 10;
   localparam int HALF = 2;
   localparam int RHI  = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic        rd_nwr_i = 1'b0;
   logic [4:0]  phy_addr_i = '0;
   logic [4:0]  reg_addr_i = '0;
   logic [15:0] wr_data_i = '0;
   logic [15:0] rd_data_o;
   logic        done_o, err_o, mdc_o, mdio_o, mdio_oe_o;
   logic        mdio_i = 1'b1;

   int n_checks = 0;
   int n_errs = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mdio_master #(.HALF_CYC(HALF), .READ_HI_CYC(RHI)) u_mdio_master (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_nwr_i(rd_nwr_i),
      .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
      .rd_data_o(rd_data_o), .done_o(done_o), .err_o(err_o), .mdc_o(mdc_o),
      .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
   );

   // PHY model and pin monitor
   int   rise_n = 0;
   bit   tx_bits [0:127];
   bit   oe_bits [0:127];
   int   hi_cnt = 0, lo_cnt = 0;
   int   tx_viol = 0, rx_viol = 0;
   int   done_seen = 0, done_dbl = 0;
   logic prev_mdc = 1'b0, prev_done = 1'b0;
   logic [15:0] phy_data = '0;
   bit   phy_ta = 1'b0;

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         if (mdc_o && !prev_mdc) begin
            if (rise_n < 128) begin
               tx_bits[rise_n] = mdio_o;
               oe_bits[rise_n] = mdio_oe_o;
            end
            if (rise_n > 0 && lo_cnt != HALF) tx_viol++;
            if (rise_n == 46) mdio_i = phy_ta;
            else if (rise_n >= 47 && rise_n <= 62 && !phy_ta) mdio_i = phy_data[62 - rise_n];
            else mdio_i = 1'b1;
            rise_n++;
            hi_cnt = 1;
         end else if (mdc_o) begin
            hi_cnt++;
         end
         if (!mdc_o && prev_mdc) begin
            if (oe_bits[rise_n-1]) begin
               if (hi_cnt != HALF) tx_viol++;
            end else begin
               if (hi_cnt != RHI) rx_viol++;
            end
            lo_cnt = 1;
         end else if (!mdc_o) begin
            lo_cnt++;
         end
         if (done_o) done_seen++;
         if (done_o && prev_done) done_dbl++;
      end
      prev_mdc  = mdc_o;
      prev_done = done_o;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   logic [15:0] model_rd = '0;
   bit          model_err = 1'b0;

   task automatic run_op(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] wd, input bit ta, input logic [15:0] pd,
                         input bit inject);
      int  wait_n;
      int  bad;
      int  exp_rises;
      bit  hdr [0:13];
      @(negedge clk);
      rise_n = 0; tx_viol = 0; rx_viol = 0; done_seen = 0; done_dbl = 0;
      phy_ta = ta; phy_data = pd;
      rd_nwr_i = rd; phy_addr_i = pa; reg_addr_i = ra; wr_data_i = wd;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      wait_n = 0;
      while (done_seen == 0 && wait_n < 2000) begin
         @(negedge clk);
         wait_n++;
         if (inject && wait_n == 40) begin
            // R10: start during the preamble, with other operands
            rd_nwr_i = !rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wr_data_i = ~wd;
            start_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
      end
      chk(done_seen != 0, "R11", "done timeout", wait_n, 2000);
      repeat (30) @(negedge clk);
      // R1: idle pins after the frame
      chk(!mdc_o && !mdio_oe_o, "R1", "idle pins", {mdc_o, mdio_oe_o}, 0);
      // R11 / R10: exactly one single-cycle done
      chk(done_seen == 1 && done_dbl == 0, "R11", "done count", done_seen, 1);
      if (inject) chk(done_seen == 1, "R10", "extra frame", done_seen, 1);
      // R2: preamble
      bad = 0;
      for (int k = 0; k < 32; k++) if (!tx_bits[k] || !oe_bits[k]) bad++;
      chk(bad == 0, "R2", "preamble bits", bad, 0);
      // R3 / R4: start, opcode, addresses
      hdr[0] = 0; hdr[1] = 1; hdr[2] = rd; hdr[3] = !rd;
      for (int k = 0; k < 5; k++) begin
         hdr[4+k] = pa[4-k];
         hdr[9+k] = ra[4-k];
      end
      bad = 0;
      for (int k = 0; k < 4; k++) if (tx_bits[32+k] != hdr[k] || !oe_bits[32+k]) bad++;
      chk(bad == 0, "R3", "start/opcode", bad, 0);
      bad = 0;
      for (int k = 4; k < 14; k++) if (tx_bits[32+k] != hdr[k] || !oe_bits[32+k]) bad++;
      chk(bad == 0, "R4", "address fields", bad, 0);
      chk(tx_viol == 0, "R8", "driven bit timing", tx_viol, 0);
      chk(rx_viol == 0, "R9", "receive bit timing", rx_viol, 0);
      if (!rd) begin
         bad = 0;
         if (!tx_bits[46] || tx_bits[47]) bad++;
         for (int k = 0; k < 16; k++) if (tx_bits[48+k] != wd[15-k]) bad++;
         for (int k = 46; k < 64; k++) if (!oe_bits[k]) bad++;
         if (oe_bits[64]) bad++;
         chk(bad == 0, "R5", "write tail bits", bad, 0);
         chk(rise_n == 65, "R5", "write MDC count", rise_n, 65);
         model_err = 1'b0;
      end else if (!ta) begin
         bad = 0;
         for (int k = 46; k < 64; k++) if (oe_bits[k]) bad++;
         chk(bad == 0, "R6", "read release", bad, 0);
         chk(rise_n == 64, "R6", "read MDC count", rise_n, 64);
         model_rd = pd; model_err = 1'b0;
      end else begin
         chk(rise_n == 79, "R7", "flush MDC count", rise_n, 79);
         model_rd = 16'hFFFF; model_err = 1'b1;
      end
      chk(rd_data_o == model_rd, rd ? (ta ? "R7" : "R6") : "R11", "rd_data", rd_data_o, model_rd);
      chk(err_o == model_err, rd ? (ta ? "R7" : "R6") : "R11", "err", err_o, model_err);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!mdc_o && !mdio_oe_o && !done_o && rd_data_o == 0 && !err_o, "R1", "reset state",
          {mdc_o, mdio_oe_o, done_o, err_o}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(!mdc_o && !mdio_oe_o && !done_o, "R1", "idle after reset", {mdc_o, mdio_oe_o}, 0);
      for (int i = 0; i < 32; i++) begin
         run_op(1'b0, 5'(i), 5'((i * 7) % 32), 16'(i * 16'h1357) ^ 16'hA5C3, 1'b0, 16'h0, i == 5);
         run_op(1'b1, 5'(31 - i), 5'(i), 16'h0, 1'b0, 16'(i * 16'h0F0F + 16'h1234), i == 6);
         if (i % 4 == 0) begin
            run_op(1'b1, 5'(i), 5'(i ^ 5'h15), 16'h0, 1'b1, 16'h5A5A, 1'b0);
            // R11: write after failed read clears err, keeps data
            run_op(1'b0, 5'(i), 5'(i), 16'(i * 3), 1'b0, 16'h0, 1'b0);
         end
      end
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

   always @(posedge clk) begin
      if (cycles > 150000) begin
         n_checks++;
         n_errs++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

endmodule